// File: doc/BRIEF.md
# Four-Lane Bidirectional Shift-Latch Driver

This block turns four serial bit streams into one 32-bit parallel word for a bank of display column drivers. Four 8-stage shift registers share a clock. Each takes one bit per rising edge from its own serial input. A direction input chooses whether the bits move toward the higher-numbered stage or toward the lower-numbered one. Each lane's end stage is available as a serial cascade output, so several blocks can be chained.

A load-enable input copies the shift contents into a hold stage. While load-enable is high the hold stage follows the shift registers. While it is low the hold stage keeps its value, and shifting goes on regardless. The held word then passes through output gating. Chip select overrides everything else. Per-lane blanking comes next, and a global polarity control is applied last. The gated word is captured in an output register.

Top module: `qsl_driver`

## Requirements
- R1: A synchronous active-high `rst` clears all shift stages, the hold stage and the output register to zero; `drv_out` reads 0 in the cycle after reset is released.
- R2: With `shift_fwd` high, each rising edge moves every lane's stage n to stage n+1, loads `sdin[lane]` into stage 1, and `sdout[lane]` shows stage 8.
- R3: With `shift_fwd` low, each rising edge moves every lane's stage n to stage n-1, loads `sdin[lane]` into stage 8, and `sdout[lane]` shows stage 1.
- R4: `load_en` has no effect on shifting: the shift registers and `sdout` advance on every edge at either level of `load_en`.
- R5: On an edge where `load_en` is high, the hold stage takes the shift contents written at that same edge. While `load_en` is low, the hold stage keeps its value.
- R6: When `chip_en` is low, every bit of `drv_out` is driven to the inverse of `pol_true` (all ones when `pol_true`=0, all zeros when `pol_true`=1), whatever the data and `lane_en`.
- R7: With `chip_en` high, `lane_en[l]`=0 forces the pre-polarity value of all eight bits of lane l to 0, so they read 0 when `pol_true`=1 and 1 when `pol_true`=0. Other lanes are unaffected.
- R8: With `chip_en` high and a lane enabled, its bits equal the held data when `pol_true`=1 and the inverse of the held data when `pol_true`=0.
- R9: Output mapping: stage k (1..8) of lane l (A=0..D=3) drives `drv_out[4*(k-1)+l]`.
- R10: `drv_out` is registered: on each edge it takes the gated value of the hold stage as it stood before that edge, together with the control levels present at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| sdin | input | 4 | Serial data, one bit per lane (bit 0 = lane A) |
| shift_fwd | input | 1 | 1: shift toward stage 8; 0: shift toward stage 1 |
| load_en | input | 1 | 1: hold stage follows shift registers; 0: hold |
| chip_en | input | 1 | 0: force all outputs to the inverse of `pol_true` |
| pol_true | input | 1 | 1: data passes unchanged; 0: outputs inverted |
| lane_en | input | 4 | Per-lane enable; 0 blanks that lane |
| drv_out | output | 32 | Registered parallel driver word, lane-interleaved per stage |
| sdout | output | 4 | Serial cascade output per lane |

## Verification
The shift movement in both directions, the hold stage following the shift contents or holding, the chip-select force and per-lane blanking are checked on every cycle against internal state and ports. Only the bench's scenarios show the following: the lane-interleaved bit mapping with literal single-bit patterns, the complete polarity and blanking combinations against an independent model, and the fact that shifting continues while the held word stays frozen.

// File: rtl/qsl_pkg.sv
package qsl_pkg;
  localparam int unsigned LANES_DEF  = 4;
  localparam int unsigned STAGES_DEF = 8;
endpackage

// File: rtl/qsl_lane.sv
// One serial lane: bidirectional shift register with cascade tap.
module qsl_lane #(
  parameter int unsigned STAGES = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fwd,
  input  logic              din,
  output logic [STAGES-1:0] q,
  output logic [STAGES-1:0] q_next,
  output logic              cascade
);
  always_comb begin
    if (fwd) q_next = {q[STAGES-2:0], din};
    else     q_next = {din, q[STAGES-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end

  assign cascade = fwd ? q[STAGES-1] : q[0];
endmodule

// File: rtl/qsl_hold.sv
// Level-controlled hold register standing in for a transparent latch.
module qsl_hold #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/qsl_gate.sv
// Output gating (chip select > lane blank > polarity) and output register.
module qsl_gate #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned STAGES = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      chip_en,
  input  logic                      pol_true,
  input  logic [LANES-1:0]          lane_en,
  input  logic [LANES*STAGES-1:0]   held,
  output logic [LANES*STAGES-1:0]   drv
);
  localparam int unsigned NBITS = LANES * STAGES;

  logic [NBITS-1:0] gated;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic pre;
      assign pre = lane_en[l] & held[l*STAGES + s];
      assign gated[s*LANES + l] = !chip_en ? ~pol_true
                                           : (pol_true ? pre : ~pre);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) drv <= '0;
    else     drv <= gated;
  end
endmodule

// File: rtl/qsl_driver.sv
module qsl_driver
  import qsl_pkg::*;
#(
  parameter int unsigned LANES  = LANES_DEF,
  parameter int unsigned STAGES = STAGES_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        sdin,
  input  logic                    shift_fwd,
  input  logic                    load_en,
  input  logic                    chip_en,
  input  logic                    pol_true,
  input  logic [LANES-1:0]        lane_en,
  output logic [LANES*STAGES-1:0] drv_out,
  output logic [LANES-1:0]        sdout
);
  localparam int unsigned NBITS = LANES * STAGES;

  // Lane-major internal layout: bit l*STAGES + s is stage s+1 of lane l.
  logic [NBITS-1:0] sr_flat;
  logic [NBITS-1:0] sr_next;
  logic [NBITS-1:0] latch_flat;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    qsl_lane #(.STAGES(STAGES)) u_lane (
      .clk     (clk),
      .rst     (rst),
      .fwd     (shift_fwd),
      .din     (sdin[l]),
      .q       (sr_flat[l*STAGES +: STAGES]),
      .q_next  (sr_next[l*STAGES +: STAGES]),
      .cascade (sdout[l])
    );
  end

  qsl_hold #(.W(NBITS)) u_hold (
    .clk (clk),
    .rst (rst),
    .en  (load_en),
    .d   (sr_next),
    .q   (latch_flat)
  );

  qsl_gate #(.LANES(LANES), .STAGES(STAGES)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .chip_en  (chip_en),
    .pol_true (pol_true),
    .lane_en  (lane_en),
    .held     (latch_flat),
    .drv      (drv_out)
  );
endmodule

// File: rtl/qsl_driver_chk.sv
module qsl_driver_chk #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned STAGES = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic [LANES-1:0]        sdin,
  input logic                    shift_fwd,
  input logic                    load_en,
  input logic                    chip_en,
  input logic                    pol_true,
  input logic [LANES-1:0]        lane_en,
  input logic [LANES*STAGES-1:0] sr_flat,
  input logic [LANES*STAGES-1:0] latch_flat,
  input logic [LANES*STAGES-1:0] drv_out
);
  // R5: hold stage matches shift contents after a loading edge
  p_follow_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(load_en) |-> latch_flat == sr_flat);

  // R5: hold stage keeps its value while load_en is low
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(load_en) |-> $stable(latch_flat));

  // R6: chip select low forces every output
  p_cs_force_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(chip_en) |-> drv_out == {(LANES*STAGES){~$past(pol_true)}});

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [STAGES-1:0] lane_bits;
    for (genvar s = 0; s < STAGES; s++) begin : g_bit
      assign lane_bits[s] = drv_out[s*LANES + l];
    end

    // R2: forward shift moves stages up and loads stage 1
    p_fwd_shift_r2: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(shift_fwd) |->
        sr_flat[l*STAGES +: STAGES] ==
        {$past(sr_flat[l*STAGES +: STAGES-1]), $past(sdin[l])});

    // R3: reverse shift moves stages down and loads stage 8
    p_rev_shift_r3: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && !$past(shift_fwd) |->
        sr_flat[l*STAGES +: STAGES] ==
        {$past(sdin[l]), $past(sr_flat[l*STAGES+1 +: STAGES-1])});

    // R7: a blanked lane under true polarity reads all zero
    p_blank_r7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) && $past(chip_en) && $past(pol_true) && !$past(lane_en[l])
        |-> lane_bits == '0);
  end
endmodule

bind qsl_driver qsl_driver_chk #(.LANES(LANES), .STAGES(STAGES)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .sdin       (sdin),
  .shift_fwd  (shift_fwd),
  .load_en    (load_en),
  .chip_en    (chip_en),
  .pol_true   (pol_true),
  .lane_en    (lane_en),
  .sr_flat    (sr_flat),
  .latch_flat (latch_flat),
  .drv_out    (drv_out)
);

// File: tb/test_qsl_driver.sv
module test_qsl_driver;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  sdin = '0;
  logic        shift_fwd = 1'b1;
  logic        load_en = 1'b0;
  logic        chip_en = 1'b1;
  logic        pol_true = 1'b1;
  logic [3:0]  lane_en = 4'hF;
  logic [31:0] drv_out;
  logic [3:0]  sdout;

  int n_chk = 0;
  int n_fail = 0;

  // Bench model: lane l stage k held in m_sr[l][k-1]
  logic [3:0][7:0] m_sr, m_lat;
  logic [31:0]     m_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  qsl_driver i_qsl_driver (
    .clk(clk), .rst(rst), .sdin(sdin), .shift_fwd(shift_fwd),
    .load_en(load_en), .chip_en(chip_en), .pol_true(pol_true),
    .lane_en(lane_en), .drv_out(drv_out), .sdout(sdout)
  );

  function automatic logic [31:0] f_gate(logic [3:0][7:0] lat, logic cs,
                                         logic pol, logic [3:0] en);
    logic [31:0] r;
    for (int k = 0; k < 8; k++)
      for (int l = 0; l < 4; l++) begin
        logic pre;
        pre = en[l] & lat[l][k];
        r[4*k+l] = !cs ? ~pol : (pol ? pre : ~pre);
      end
    return r;
  endfunction

  function automatic logic [3:0] f_casc(logic [3:0][7:0] sr, logic fwd);
    logic [3:0] r;
    for (int l = 0; l < 4; l++) r[l] = fwd ? sr[l][7] : sr[l][0];
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; applies one rising edge and updates the model.
  task automatic step(input logic [3:0] bits);
    sdin = bits;
    @(posedge clk);
    m_drv = f_gate(m_lat, chip_en, pol_true, lane_en);
    for (int l = 0; l < 4; l++)
      m_sr[l] = shift_fwd ? {m_sr[l][6:0], bits[l]} : {bits[l], m_sr[l][7:1]};
    if (load_en) m_lat = m_sr;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_sr = '0; m_lat = '0; m_drv = '0;
    chk("R1 drv_out after reset", drv_out, 32'h0);
    chk("R1 sdout after reset", {28'h0, sdout}, 32'h0);
    step(4'h0);
    chk("R1 drv_out first cycle", drv_out, 32'h0);
  endtask

  task automatic t_forward;
    shift_fwd = 1'b1; load_en = 1'b1; chip_en = 1'b1; pol_true = 1'b1; lane_en = 4'hF;
    for (int i = 0; i < 8; i++) begin
      step(4'(i * 5 + 3));
      chk("R2 forward cascade", {28'h0, sdout}, {28'h0, f_casc(m_sr, 1'b1)});
    end
    load_en = 1'b0;
    step(4'h0);
    chk("R2 R9 forward word", drv_out, m_drv);
    // single marker: lane B stage 1 -> bit 1
    load_en = 1'b1;
    for (int i = 0; i < 7; i++) step(4'h0);
    step(4'b0010);
    load_en = 1'b0;
    step(4'h0);
    chk("R9 lane B stage 1 bit", drv_out, 32'h0000_0002);
  endtask

  task automatic t_reverse;
    shift_fwd = 1'b0; load_en = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step(4'(i * 7 + 9));
      chk("R3 reverse cascade", {28'h0, sdout}, {28'h0, f_casc(m_sr, 1'b0)});
    end
    load_en = 1'b0;
    step(4'h0);
    chk("R3 reverse word", drv_out, m_drv);
    // single marker: lane D stage 8 -> bit 31
    load_en = 1'b1;
    for (int i = 0; i < 7; i++) step(4'h0);
    step(4'b1000);
    load_en = 1'b0;
    step(4'h0);
    chk("R3 R9 lane D stage 8 bit", drv_out, 32'h8000_0000);
  endtask

  task automatic t_hold;
    logic [31:0] frozen;
    frozen = drv_out;
    shift_fwd = 1'b1; load_en = 1'b0;
    for (int i = 0; i < 8; i++) begin
      step(4'(15 - i));
      chk("R4 shifting with load_en low", {28'h0, sdout}, {28'h0, f_casc(m_sr, 1'b1)});
      chk("R5 held word frozen", drv_out, frozen);
    end
    load_en = 1'b1;
    step(4'h6);
    load_en = 1'b0;
    step(4'h0);
    chk("R5 load takes same-edge contents", drv_out, m_drv);
  endtask

  task automatic t_gating;
    logic [3:0] pats [5] = '{4'hF, 4'hE, 4'h0, 4'h5, 4'hA};
    load_en = 1'b0;
    for (int c = 0; c < 2; c++)
      for (int p = 0; p < 2; p++)
        for (int e = 0; e < 5; e++) begin
          chip_en = c[0]; pol_true = p[0]; lane_en = pats[e];
          step(4'h0);
          if (!c[0])
            chk("R6 chip select force", drv_out, {32{~p[0]}});
          else if (pats[e] != 4'hF)
            chk("R7 lane blank", drv_out, m_drv);
          else
            chk("R8 polarity", drv_out, m_drv);
          if (c[0] && p[0] && !pats[e][0])
            chk("R7 lane A blanked reads zero", drv_out & 32'h1111_1111, 32'h0);
          if (c[0] && !p[0] && !pats[e][0])
            chk("R7 lane A blanked inverted", drv_out & 32'h1111_1111, 32'h1111_1111);
        end
    // R10: change polarity with no clock; output must not move until an edge
    chip_en = 1'b1; lane_en = 4'hF; pol_true = 1'b1;
    step(4'h0);
    pol_true = 1'b0;
    #(CLK_PERIOD/4);
    chk("R10 output registered", drv_out, m_drv);
    @(negedge clk);
    step(4'h0);
    chk("R10 output after edge", drv_out, m_drv);
    pol_true = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_sr = '0; m_lat = '0; m_drv = '0;
    @(negedge clk);
    t_reset();
    t_forward();
    t_reverse();
    t_hold();
    t_gating();
    t_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule